// File: doc/BRIEF.md
# Wakeup interrupt sense-normalising front-end

This block sits in an always-on domain between a set of peripheral interrupt pins and a downstream interrupt controller. The downstream controller only understands active-high levels and rising edges. Each pin has its own 3-bit sense code, so the block can turn an active-low level into an active-high level. It also turns a falling edge, or a transition in either direction, into a rising edge. Every pin first passes through a synchroniser. Its event then lands in a per-pin pending bit, and a banked enable register gates it.

While the consumer domain is powered down, its power-good input is low. In that state the block keeps every output low, holds pending events, and raises a wake request. When power-good returns, the request drops and the held events show on the outputs, where the consumer sees them as fresh rising edges. A simple write-strobe register bus with combinational read data reaches three register groups: the enable banks, the per-pin sense words and a write-one-to-clear pending status bank.

Top module: `wake_sense_front`

## Requirements
- R1: Enable bit for pin p is bit p mod 32 of the word at byte address 0x10 + 4*(p div 32). Bits for pins at or beyond the pin count read as 0. All enables reset to 0.
- R2: The sense code of pin p is held in bits 2:0 of the word at 0x110 + 4*p. It reads back with the upper bits as 0.
- R3: Code 3'b000 (active-low level): while power-good is high, irq_o[p] is the inverse of the pin.
- R4: Code 3'b100 (active-high level): while power-good is high, irq_o[p] follows the pin.
- R5: Code 3'b010 (falling edge): a 1-to-0 transition sets the pending bit and a 0-to-1 transition does not.
- R6: Code 3'b110 (rising edge): a 0-to-1 transition sets the pending bit and a 1-to-0 transition does not.
- R7: Code 3'b111 (both edges): a transition in either direction sets the pending bit.
- R8: An edge pending bit stays set after the pin settles. It is cleared either by a pulse on ack_i[p] or by writing 1 to bit p mod 32 of the status word at 0x400 + 4*(p div 32). That status word reads the pending bits.
- R9: A pin whose enable bit is 0, or whose code is not one of the five codes above, drives no output and clears its pending bit.
- R10: While pwr_good_i is low, every irq_o bit is 0 and pending bits are held. They appear on irq_o as soon as pwr_good_i is high again.
- R11: wake_req_o rises one clock after any pending bit is set while pwr_good_i is low. It stays high until pwr_good_i is high, and is low on the following clock.
- R12: A pin change sampled at one rising clock edge reaches irq_o after the third rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | N_PINS | Asynchronous interrupt pins |
| ack_i | input | N_PINS | Per-pin consumer acknowledge, clears edge pending |
| pwr_good_i | input | 1 | Consumer domain power is good |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | AW | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | N_PINS | Normalised interrupts to the consumer |
| wake_req_o | output | 1 | Power-up request for the consumer domain |

## Verification
Random trials pick a pin, a sense code (invalid ones included), an enable and a start and end pin level. The result is compared with a bench function of the code and the two levels. This sorts out level from edge handling and the direction of each edge mode. A fixed set of cases covers the rest. The top enable bank is written with all ones, to check that pins past the count are trimmed. One pin is timed against the synchroniser latency, to find a missing or extra stage. Ack and status clears are compared with a pin that has settled. Sleep, wake and replay are run in sequence, to check that pending bits are held while power is off and released when it returns.

// File: rtl/wsf_pkg.sv
package wsf_pkg;
   typedef enum logic [2:0] {
      SNS_LVL_LO = 3'b000,
      SNS_FALL   = 3'b010,
      SNS_LVL_HI = 3'b100,
      SNS_RISE   = 3'b110,
      SNS_BOTH   = 3'b111
   } sense_e;

   localparam int WORD_W = 32;
endpackage

// File: rtl/wsf_regs.sv
module wsf_regs
   import wsf_pkg::*;
#(
   parameter int N_PINS    = 126,
   parameter int AW        = 12,
   parameter int EN_BASE   = 'h010,
   parameter int CFG_BASE  = 'h110,
   parameter int STAT_BASE = 'h400
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [AW-1:0]       addr,
   input  logic [WORD_W-1:0]   wdata,
   output logic [WORD_W-1:0]   rdata,
   input  logic [N_PINS-1:0]   pend,
   output logic [N_PINS-1:0]   en_vec,
   output logic [3*N_PINS-1:0] cfg_flat,
   output logic [N_PINS-1:0]   clr_vec
);
   localparam int NB   = (N_PINS + WORD_W - 1) / WORD_W;
   localparam int PADW = NB * WORD_W;
   localparam logic [PADW-1:0] LIVE = PADW'({N_PINS{1'b1}});

   logic [PADW-1:0]     en_q;
   logic [3*N_PINS-1:0] cfg_q;
   logic [PADW-1:0]     clr_pad;
   logic [PADW-1:0]     pend_pad;

   assign pend_pad = PADW'(pend);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         cfg_q <= '0;
      end else if (we) begin
         for (int b = 0; b < NB; b++)
            if (addr == AW'(EN_BASE + 4*b))
               en_q[b*WORD_W +: WORD_W] <= wdata & LIVE[b*WORD_W +: WORD_W];
         for (int p = 0; p < N_PINS; p++)
            if (addr == AW'(CFG_BASE + 4*p))
               cfg_q[3*p +: 3] <= wdata[2:0];
      end
   end

   always_comb begin
      clr_pad = '0;
      if (we)
         for (int b = 0; b < NB; b++)
            if (addr == AW'(STAT_BASE + 4*b))
               clr_pad[b*WORD_W +: WORD_W] = wdata;
   end

   always_comb begin
      rdata = '0;
      for (int b = 0; b < NB; b++) begin
         if (addr == AW'(EN_BASE + 4*b))   rdata = en_q[b*WORD_W +: WORD_W];
         if (addr == AW'(STAT_BASE + 4*b)) rdata = pend_pad[b*WORD_W +: WORD_W];
      end
      for (int p = 0; p < N_PINS; p++)
         if (addr == AW'(CFG_BASE + 4*p)) rdata = {29'b0, cfg_q[3*p +: 3]};
   end

   assign en_vec   = en_q[N_PINS-1:0];
   assign cfg_flat = cfg_q;
   assign clr_vec  = clr_pad[N_PINS-1:0];
endmodule

// File: rtl/wsf_lane.sv
module wsf_lane
   import wsf_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_async,
   input  logic       en,
   input  logic [2:0] cfg,
   input  logic       ack,
   input  logic       clr,
   output logic       pend
);
   logic [SYNC_STAGES:0] sh;
   logic cur, prev, keep, nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-1:0], pin_async};
   end

   assign cur  = sh[SYNC_STAGES-1];
   assign prev = sh[SYNC_STAGES];
   assign keep = pend & ~(ack | clr);

   always_comb begin
      case (cfg)
         SNS_LVL_LO: nxt = ~cur;
         SNS_LVL_HI: nxt = cur;
         SNS_FALL:   nxt = (prev & ~cur) | keep;
         SNS_RISE:   nxt = (~prev & cur) | keep;
         SNS_BOTH:   nxt = (prev ^ cur) | keep;
         default:    nxt = 1'b0;
      endcase
      if (!en) nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= nxt;
   end
endmodule

// File: rtl/wsf_wake.sv
module wsf_wake (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   input  logic any_pend,
   output logic wake_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        wake_req <= 1'b0;
      else if (pwr_good) wake_req <= 1'b0;
      else               wake_req <= wake_req | any_pend;
   end
endmodule

// File: rtl/wake_sense_front.sv
module wake_sense_front
   import wsf_pkg::*;
#(
   parameter int N_PINS      = 126,
   parameter int AW          = 12,
   parameter int SYNC_STAGES = 2,
   parameter int EN_BASE     = 'h010,
   parameter int CFG_BASE    = 'h110,
   parameter int STAT_BASE   = 'h400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pin_i,
   input  logic [N_PINS-1:0] ack_i,
   input  logic              pwr_good_i,
   input  logic              bus_we_i,
   input  logic [AW-1:0]     bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic [N_PINS-1:0] irq_o,
   output logic              wake_req_o
);
   localparam int NB = (N_PINS + WORD_W - 1) / WORD_W;

   if (N_PINS < 1 || N_PINS > 126) begin : g_bad_pins
      $error("wake_sense_front: N_PINS out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("wake_sense_front: SYNC_STAGES below 2");
   end
   if (CFG_BASE < EN_BASE + 4*NB || STAT_BASE < CFG_BASE + 4*N_PINS ||
       STAT_BASE + 4*NB > (1 << AW)) begin : g_bad_map
      $error("wake_sense_front: register groups overlap or exceed AW");
   end

   logic [N_PINS-1:0]   en_vec;
   logic [N_PINS-1:0]   clr_vec;
   logic [N_PINS-1:0]   pend_vec;
   logic [3*N_PINS-1:0] cfg_flat;

   wsf_regs #(
      .N_PINS(N_PINS), .AW(AW), .EN_BASE(EN_BASE),
      .CFG_BASE(CFG_BASE), .STAT_BASE(STAT_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we_i), .addr(bus_addr_i),
      .wdata(bus_wdata_i), .rdata(bus_rdata_o), .pend(pend_vec),
      .en_vec(en_vec), .cfg_flat(cfg_flat), .clr_vec(clr_vec)
   );

   for (genvar p = 0; p < N_PINS; p++) begin : g_lane
      wsf_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
         .clk(clk), .rst_n(rst_n), .pin_async(pin_i[p]), .en(en_vec[p]),
         .cfg(cfg_flat[3*p +: 3]), .ack(ack_i[p]), .clr(clr_vec[p]),
         .pend(pend_vec[p])
      );
   end

   wsf_wake u_wake (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good_i),
      .any_pend(|pend_vec), .wake_req(wake_req_o)
   );

   assign irq_o = pend_vec & {N_PINS{pwr_good_i}};
endmodule

// File: rtl/wsf_check.sv
module wsf_check #(
   parameter int N_PINS = 126
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwr_good,
   input logic [N_PINS-1:0] en,
   input logic [N_PINS-1:0] pend,
   input logic              wake
);
   AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ((~$past(en)) & pend) == '0); // R9
   AST_WAKE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_good && (|pend)) |=> wake); // R11
   AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wake && !pwr_good) |=> wake); // R11
   AST_WAKE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_good |=> !wake); // R11
endmodule

bind wake_sense_front wsf_check #(.N_PINS(N_PINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good_i),
   .en(en_vec), .pend(pend_vec), .wake(wake_req_o)
);

// File: tb/wake_sense_front_test.sv
module wake_sense_front_test;
   localparam int N = 126;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pins = '0;
   logic [N-1:0]  ack = '0;
   logic          pgood = 1'b1;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [N-1:0]  irq;
   logic          wake;

   int n_chk = 0;
   int n_bad = 0;
   logic [127:0] en_sh = '0;

   always #10 clk = ~clk;

   wake_sense_front uut (
      .clk(clk), .rst_n(rst_n), .pin_i(pins), .ack_i(ack), .pwr_good_i(pgood),
      .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .irq_o(irq), .wake_req_o(wake)
   );

   function automatic logic lvl_exp(logic [2:0] c, logic v);
      case (c)
         3'b000:  return ~v;
         3'b100:  return v;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic edge_exp(logic [2:0] c, logic o, logic n);
      case (c)
         3'b010:  return o & ~n;
         3'b110:  return ~o & n;
         3'b111:  return o ^ n;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      @(negedge clk);
      addr = AW'(a);
      #1 d = rdata;
   endtask

   task automatic set_en(int p, logic v);
      en_sh[p] = v;
      wr('h10 + 4*(p/32), en_sh[(p/32)*32 +: 32]);
   endtask

   task automatic w1c(int p);
      wr('h400 + 4*(p/32), 32'h1 << (p % 32));
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // Reset state (R1, R11)
      rd('h10, d);  check("R1 reset enable", d, 0);
      check("R10 reset irq", 32'(|irq), 0);
      check("R11 reset wake", 32'(wake), 0);

      // R1 bank trim on the top bank
      wr('h1C, 32'hFFFF_FFFF);
      rd('h1C, d);  check("R1 top bank trim", d, 32'h3FFF_FFFF);
      wr('h1C, 0);
      rd('h1C, d);  check("R1 clear", d, 0);

      // R2 config readback
      wr('h110 + 4*125, 32'hFFFF_FFF6);
      rd('h110 + 4*125, d); check("R2 cfg pin125", d, 6);
      wr('h110, 32'h5);
      rd('h110, d); check("R2 cfg pin0", d, 5);
      wr('h110 + 4*125, 0);

      // R12 latency, R4 level high on pin 5
      wr('h110 + 4*5, 3'b100);
      set_en(5, 1'b1);
      settle();
      @(negedge clk); pins[5] = 1'b1;
      repeat (2) @(negedge clk);
      check("R12 not after two edges", 32'(irq[5]), 0);
      @(negedge clk);
      check("R12 after three edges", 32'(irq[5]), 1);
      check("R4 level high", 32'(irq[5]), 1);
      pins[5] = 1'b0; settle();
      check("R4 level high drop", 32'(irq[5]), 0);
      // R3 active low on same pin
      wr('h110 + 4*5, 3'b000); settle();
      check("R3 active low", 32'(irq[5]), 1);
      set_en(5, 1'b0); settle();
      check("R9 disable level", 32'(irq[5]), 0);

      // R8 edge pending on pin 64, cleared by ack then by status write
      wr('h110 + 4*64, 3'b110);
      set_en(64, 1'b1); settle();
      pins[64] = 1'b1; settle(); settle();
      check("R8 held", 32'(irq[64]), 1);
      rd('h408, d); check("R8 status read", d, 1);
      @(negedge clk); ack[64] = 1'b1; @(negedge clk); ack[64] = 1'b0;
      @(negedge clk);
      check("R8 ack clear", 32'(irq[64]), 0);
      pins[64] = 1'b0; settle();
      check("R6 falling ignored", 32'(irq[64]), 0);
      pins[64] = 1'b1; settle();
      w1c(64); @(negedge clk);
      check("R8 w1c clear", 32'(irq[64]), 0);

      // R10 / R11 sleep, wake request and replay
      pgood = 1'b0;
      pins[64] = 1'b0; settle();
      pins[64] = 1'b1; settle();
      check("R10 quiet asleep", 32'(irq[64]), 0);
      check("R11 wake raised", 32'(wake), 1);
      repeat (5) @(negedge clk);
      check("R11 wake held", 32'(wake), 1);
      pgood = 1'b1; #1;
      check("R10 replay", 32'(irq[64]), 1);
      @(negedge clk);
      check("R11 wake dropped", 32'(wake), 0);

      // R9 disable clears edge pending, invalid code
      set_en(64, 1'b0); @(negedge clk);
      check("R9 disable clears", 32'(irq[64]), 0);
      set_en(64, 1'b1); @(negedge clk);
      check("R9 no return", 32'(irq[64]), 0);
      wr('h110 + 4*64, 3'b101); settle();
      check("R9 invalid code", 32'(irq[64]), 0);
      set_en(64, 1'b0);
      pins[64] = 1'b0;

      // Random trials: R3 R4 R5 R6 R7 R9
      for (int t = 0; t < 60; t++) begin
         int p;
         logic [2:0] c;
         logic o, n, e, ex;
         logic [2:0] codes [6] = '{3'b000, 3'b010, 3'b100, 3'b110, 3'b111, 3'b011};
         p = $urandom_range(0, N-1);
         c = codes[$urandom_range(0, 5)];
         e = ($urandom_range(0, 4) != 0);
         o = 1'($urandom_range(0, 1));
         n = 1'($urandom_range(0, 1));
         pins[p] = o;
         wr('h110 + 4*p, 32'(c));
         set_en(p, e);
         settle();
         w1c(p);
         pins[p] = n;
         settle();
         ex = e & (c[1] ? edge_exp(c, o, n) : lvl_exp(c, n));
         check("R5 R6 R7 R3 R4 R9 random", 32'(irq[p]), 32'(ex));
         set_en(p, 1'b0);
         pins[p] = 1'b0;
         settle();
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule